// File: doc/BRIEF.md
# Ethernet Port Status Indicator Driver

This block turns raw line events of a 10/100 Ethernet port into three active-low indicator outputs: one for traffic, one for a good 100 Mb/s link and one for a good 10 Mb/s link. Its inputs are per-cycle strobes for transmit and receive traffic, the internal 100BASE-TX signal-detect level, a strobe for each normal link pulse seen on the wire, and a strobe for each valid 10BASE-T packet. All time constants are parameters counted in clock cycles, so the integrator scales them to the clock in use. For example, the 100 Mb/s qualification of at least 500 µs becomes 62,500 cycles at 125 MHz. Reset is synchronous and active high.

Three small state machines run side by side. The traffic machine has states ACT_IDLE, ACT_ON and ACT_HOLD:
- IDLE goes to ON on any strobe.
- ON goes to HOLD when the strobes stop.
- HOLD goes back to ON on a new strobe, or to IDLE when its hold count runs out.

The 100 Mb/s machine has states L100_DOWN, L100_QUAL and L100_UP:
- DOWN goes to QUAL when signal-detect rises.
- QUAL goes to UP once signal-detect has held for the qualification length, and falls back to DOWN on any drop.
- UP goes to DOWN on a drop.

The 10 Mb/s machine has states L10_DOWN, L10_COUNT and L10_UP:
- DOWN goes to COUNT on a link pulse, or straight to UP on a valid packet.
- COUNT goes to UP on the final pulse of the run or on a packet. It returns to DOWN when the gap since the last pulse grows too long.
- UP stays while pulses or packets keep arriving, and goes to DOWN when the link-loss timer runs out.

Top module: `eth_status_led`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, all three outputs are high (inactive).
- R2: A transmit or receive strobe sampled at a clock edge makes `act_led_n` low right after that edge.
- R3: After the last sampled strobe, `act_led_n` stays low for ACT_HOLD_CYC+1 edges and goes high after the next edge. A new strobe during that window restarts it.
- R4: `link100_led_n` goes low after the edge that samples `sig_det` high for the SD_QUAL_CYC-th consecutive time. Any low sample restarts the count from zero.
- R5: `link100_led_n` is high in any cycle where `sig_det` is low. It is a combinational drop with no clock delay.
- R6: `link10_led_n` goes low after the edge that samples the LP_NEEDED-th consecutive link pulse.
- R7: A single valid-packet strobe brings `link10_led_n` low after the edge that samples it, from any state.
- R8: Once the 10 Mb/s link is up, if neither a pulse nor a packet is sampled for LINK_LOSS_CYC edges after the last one, `link10_led_n` goes high after that edge.
- R9: Before the link is up, a pulse arriving more than LP_GAP_CYC edges after the previous one starts a new count at one.
- R10: Every pulse or packet sampled while the 10 Mb/s link is up restarts the link-loss timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_act | input | 1 | Transmit activity strobe |
| rx_act | input | 1 | Receive activity strobe |
| sig_det | input | 1 | Internal 100BASE-TX signal-detect level |
| nlp_stb | input | 1 | One-cycle strobe per normal link pulse |
| pkt_ok_stb | input | 1 | One-cycle strobe per valid 10BASE-T packet |
| act_led_n | output | 1 | Activity indicator, active low |
| link100_led_n | output | 1 | 100 Mb/s link indicator, active low |
| link10_led_n | output | 1 | 10 Mb/s link indicator, active low |

## Verification
The embedded properties check on every cycle the rules that hold at each clock edge:
- a strobe turns the activity output on;
- the activity output turns off only after a cycle with no strobe;
- a low signal-detect forces the 100 Mb/s output high;
- the 100 Mb/s output only falls at the end of a full qualification count;
- a packet or a refresh while the 10 Mb/s link is up keeps that output low;
- the 10 Mb/s output rises only when the loss timer runs out.

The exact lengths of the windows can only be shown by the bench scenarios that drive timed patterns:
- the activity stretch and its restart by a later strobe;
- the 100 Mb/s qualification, including a run that falls one sample short;
- a pulse gap that throws away a partial count;
- a refresh that postpones link loss.

// File: rtl/led_drv_pkg.sv
package led_drv_pkg;

    typedef enum logic [1:0] {
        ACT_IDLE = 2'd0,
        ACT_ON   = 2'd1,
        ACT_HOLD = 2'd2
    } act_st_t;

    typedef enum logic [1:0] {
        L100_DOWN = 2'd0,
        L100_QUAL = 2'd1,
        L100_UP   = 2'd2
    } l100_st_t;

    typedef enum logic [1:0] {
        L10_DOWN  = 2'd0,
        L10_COUNT = 2'd1,
        L10_UP    = 2'd2
    } l10_st_t;

endpackage

// File: rtl/led_act_stretch.sv
module led_act_stretch
    import led_drv_pkg::*;
#(
    parameter int HOLD_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic act_in,
    output logic led_n
);
    localparam int CW = $clog2(HOLD_CYC + 1);

    act_st_t       state, nxt;
    logic [CW-1:0] cnt;

    always_comb begin
        nxt = state;
        unique case (state)
            ACT_IDLE: nxt = act_in ? ACT_ON : ACT_IDLE;
            ACT_ON:   nxt = act_in ? ACT_ON : ACT_HOLD;
            ACT_HOLD: begin
                if (act_in)               nxt = ACT_ON;
                else if (cnt == CW'(1))   nxt = ACT_IDLE;
                else                      nxt = ACT_HOLD;
            end
            default:  nxt = ACT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ACT_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (act_in)
                cnt <= CW'(HOLD_CYC);
            else if (state == ACT_HOLD && cnt != '0)
                cnt <= cnt - CW'(1);
        end
    end

    always_comb begin
        led_n = (state == ACT_IDLE);
    end

    // R2: a sampled strobe lights the output after the edge
    p_act_on_r2: assert property (@(posedge clk) disable iff (rst)
        act_in |=> !led_n);

    // R3: the output only goes dark out of the hold phase with no strobe
    p_act_release_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(led_n) |-> ($past(state) == ACT_HOLD && !$past(act_in)));

endmodule

// File: rtl/led_link100_qual.sv
module led_link100_qual
    import led_drv_pkg::*;
#(
    parameter int QUAL_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic sd,
    output logic led_n
);
    localparam int CW = $clog2(QUAL_CYC + 1);

    l100_st_t      state, nxt;
    logic [CW-1:0] cnt;

    always_comb begin
        nxt = state;
        unique case (state)
            L100_DOWN: nxt = sd ? L100_QUAL : L100_DOWN;
            L100_QUAL: begin
                if (!sd)                          nxt = L100_DOWN;
                else if (cnt == CW'(QUAL_CYC - 1)) nxt = L100_UP;
                else                              nxt = L100_QUAL;
            end
            L100_UP:   nxt = sd ? L100_UP : L100_DOWN;
            default:   nxt = L100_DOWN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= L100_DOWN;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (!sd)
                cnt <= '0;
            else if (state != L100_UP)
                cnt <= cnt + CW'(1);
        end
    end

    always_comb begin
        led_n = !(state == L100_UP && sd);
    end

    // R5: no signal-detect, no 100 Mb/s indication
    p_l100_drop_r5: assert property (@(posedge clk) disable iff (rst)
        !sd |-> led_n);

    // R4: the indication appears only at the end of a full qualification run
    p_l100_qual_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(led_n) |-> ($past(sd) && $past(cnt) == CW'(QUAL_CYC - 1)));

endmodule

// File: rtl/led_link10_fsm.sv
module led_link10_fsm
    import led_drv_pkg::*;
#(
    parameter int PULSES   = 7,
    parameter int GAP_CYC  = 32,
    parameter int LOSS_CYC = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic nlp,
    input  logic pkt,
    output logic led_n
);
    localparam int PW   = $clog2(PULSES + 1);
    localparam int TMAX = (GAP_CYC > LOSS_CYC) ? GAP_CYC : LOSS_CYC;
    localparam int TW   = $clog2(TMAX + 1);

    l10_st_t       state, nxt;
    logic [PW-1:0] pc;
    logic [TW-1:0] tmr;

    always_comb begin
        nxt = state;
        unique case (state)
            L10_DOWN: begin
                if (pkt)      nxt = L10_UP;
                else if (nlp) nxt = L10_COUNT;
                else          nxt = L10_DOWN;
            end
            L10_COUNT: begin
                if (pkt)                              nxt = L10_UP;
                else if (nlp)                         nxt = (pc == PW'(PULSES - 1)) ? L10_UP : L10_COUNT;
                else if (tmr == TW'(GAP_CYC - 1))     nxt = L10_DOWN;
                else                                  nxt = L10_COUNT;
            end
            L10_UP: begin
                if (nlp || pkt)                       nxt = L10_UP;
                else if (tmr == TW'(LOSS_CYC - 1))    nxt = L10_DOWN;
                else                                  nxt = L10_UP;
            end
            default: nxt = L10_DOWN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= L10_DOWN;
            pc    <= '0;
            tmr   <= '0;
        end else begin
            state <= nxt;
            if (nxt != L10_COUNT)
                pc <= '0;
            else if (nlp)
                pc <= (state == L10_COUNT) ? pc + PW'(1) : PW'(1);
            if (nlp || pkt || nxt != state)
                tmr <= '0;
            else if (state != L10_DOWN)
                tmr <= tmr + TW'(1);
        end
    end

    always_comb begin
        led_n = (state != L10_UP);
    end

    // R7: one valid packet brings the link up
    p_l10_pkt_r7: assert property (@(posedge clk) disable iff (rst)
        pkt |=> !led_n);

    // R6: link comes up only from a packet or the last pulse of a full run
    p_l10_cnt_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(led_n) |-> ($past(pkt) || ($past(nlp) && $past(pc) == PW'(PULSES - 1))));

    // R10: refresh while up keeps the link
    p_l10_refresh_r10: assert property (@(posedge clk) disable iff (rst)
        ((nlp || pkt) && !led_n) |=> !led_n);

    // R8: link only drops when the loss timer has run out
    p_l10_loss_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(led_n) |-> ($past(tmr) == TW'(LOSS_CYC - 1) && !$past(nlp) && !$past(pkt)));

    // R9: the pulse-gap timer never passes its limit while counting
    p_l10_gap_r9: assert property (@(posedge clk) disable iff (rst)
        (state == L10_COUNT) |-> (tmr < TW'(GAP_CYC)));

endmodule

// File: rtl/eth_status_led.sv
module eth_status_led #(
    parameter int ACT_HOLD_CYC  = 8,
    parameter int SD_QUAL_CYC   = 16,
    parameter int LP_NEEDED     = 7,
    parameter int LP_GAP_CYC    = 32,
    parameter int LINK_LOSS_CYC = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_act,
    input  logic rx_act,
    input  logic sig_det,
    input  logic nlp_stb,
    input  logic pkt_ok_stb,
    output logic act_led_n,
    output logic link100_led_n,
    output logic link10_led_n
);
    logic any_act;

    always_comb begin
        any_act = tx_act | rx_act;
    end

    led_act_stretch #(.HOLD_CYC(ACT_HOLD_CYC)) u_act (
        .clk    (clk),
        .rst    (rst),
        .act_in (any_act),
        .led_n  (act_led_n)
    );

    led_link100_qual #(.QUAL_CYC(SD_QUAL_CYC)) u_l100 (
        .clk   (clk),
        .rst   (rst),
        .sd    (sig_det),
        .led_n (link100_led_n)
    );

    led_link10_fsm #(
        .PULSES   (LP_NEEDED),
        .GAP_CYC  (LP_GAP_CYC),
        .LOSS_CYC (LINK_LOSS_CYC)
    ) u_l10 (
        .clk   (clk),
        .rst   (rst),
        .nlp   (nlp_stb),
        .pkt   (pkt_ok_stb),
        .led_n (link10_led_n)
    );

    // R1: outputs inactive on the cycle after a reset edge
    p_reset_idle_r1: assert property (@(posedge clk)
        $past(rst) |-> (act_led_n && link100_led_n && link10_led_n));

endmodule

// File: tb/test_eth_status_led.sv
module test_eth_status_led;
    localparam int H    = 8;
    localparam int Q    = 16;
    localparam int N    = 7;
    localparam int GAP  = 32;
    localparam int LOSS = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_act = 1'b0, rx_act = 1'b0, sig_det = 1'b0, nlp_stb = 1'b0, pkt_ok_stb = 1'b0;
    logic act_led_n, link100_led_n, link10_led_n;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        int    id;
        logic  val;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    eth_status_led #(
        .ACT_HOLD_CYC(H), .SD_QUAL_CYC(Q), .LP_NEEDED(N),
        .LP_GAP_CYC(GAP), .LINK_LOSS_CYC(LOSS)
    ) i_eth_status_led (
        .clk(clk), .rst(rst), .tx_act(tx_act), .rx_act(rx_act),
        .sig_det(sig_det), .nlp_stb(nlp_stb), .pkt_ok_stb(pkt_ok_stb),
        .act_led_n(act_led_n), .link100_led_n(link100_led_n),
        .link10_led_n(link10_led_n)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // driver side: expectation at (current edge count + off), id 0=act 1=link100 2=link10
    task automatic expect_at(int off, int id, logic v, string tag);
        exp_t e;
        e.at = cyc + off; e.id = id; e.val = v; e.tag = tag;
        sb.push_back(e);
    endtask

    function automatic logic pick(int id);
        if (id == 0) return act_led_n;
        if (id == 1) return link100_led_n;
        return link10_led_n;
    endfunction

    // monitor: compare due expectations away from the active edge
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at == cyc) begin
                n_checks++;
                if (pick(sb[i].id) !== sb[i].val) begin
                    n_fail++;
                    $display("FAIL %s: output %0d got %b expected %b at cycle %0d",
                             sb[i].tag, sb[i].id, pick(sb[i].id), sb[i].val, cyc);
                end
                sb.delete(i);
            end
        end
    end

    task automatic link_pulse(int spacing);
        nlp_stb = 1'b1;
        tick();
        nlp_stb = 1'b0;
        repeat (spacing - 1) tick();
    endtask

    task automatic finish_run();
        done = 1'b1;
        n_checks += sb.size();
        foreach (sb[i]) begin
            n_fail++;
            $display("FAIL %s: check never reached, got - expected %b", sb[i].tag, sb[i].val);
        end
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) tick();
        // R1: reset state
        expect_at(0, 0, 1'b1, "R1");
        expect_at(0, 1, 1'b1, "R1");
        expect_at(0, 2, 1'b1, "R1");
        rst = 1'b0;
        expect_at(1, 0, 1'b1, "R1");
        expect_at(1, 2, 1'b1, "R1");
        tick();

        // R2/R3: single transmit strobe and its stretch
        expect_at(1, 0, 1'b0, "R2");
        expect_at(1 + H, 0, 1'b0, "R3");
        expect_at(2 + H, 0, 1'b1, "R3");
        tx_act = 1'b1;
        tick();
        tx_act = 1'b0;
        repeat (H + 4) tick();

        // R2/R3: receive strobe, then a second one restarts the hold
        expect_at(1, 0, 1'b0, "R2");
        rx_act = 1'b1;
        tick();
        rx_act = 1'b0;
        repeat (3) tick();
        expect_at(H - 2, 0, 1'b0, "R3");
        expect_at(1 + H, 0, 1'b0, "R3");
        expect_at(2 + H, 0, 1'b1, "R3");
        rx_act = 1'b1;
        tick();
        rx_act = 1'b0;
        repeat (H + 4) tick();

        // R4/R5: qualified 100 Mb/s link, then immediate drop
        expect_at(Q - 1, 1, 1'b1, "R4");
        expect_at(Q, 1, 1'b0, "R4");
        sig_det = 1'b1;
        repeat (Q + 3) tick();
        sig_det = 1'b0;
        expect_at(0, 1, 1'b1, "R5");
        tick();

        // R4: one sample short, glitch, then a full run
        sig_det = 1'b1;
        repeat (Q - 1) tick();
        expect_at(0, 1, 1'b1, "R4");
        sig_det = 1'b0;
        tick();
        sig_det = 1'b1;
        expect_at(Q - 1, 1, 1'b1, "R4");
        expect_at(Q, 1, 1'b0, "R4");
        repeat (Q + 2) tick();
        sig_det = 1'b0;
        expect_at(0, 1, 1'b1, "R5");
        tick();

        // R6: seven link pulses
        repeat (N - 1) link_pulse(10);
        expect_at(0, 2, 1'b1, "R6");
        expect_at(1, 2, 1'b0, "R6");
        nlp_stb = 1'b1;
        tick();
        nlp_stb = 1'b0;
        repeat (39) tick();
        // R10: refresh postpones the loss
        expect_at(0, 2, 1'b0, "R10");
        expect_at(26, 2, 1'b0, "R10");
        expect_at(LOSS, 2, 1'b0, "R8");
        expect_at(LOSS + 1, 2, 1'b1, "R8");
        nlp_stb = 1'b1;
        tick();
        nlp_stb = 1'b0;
        repeat (LOSS + 3) tick();

        // R9: a long gap discards a partial count
        repeat (N - 1) link_pulse(10);
        repeat (30) tick();
        repeat (N - 1) link_pulse(10);
        expect_at(0, 2, 1'b1, "R9");
        expect_at(1, 2, 1'b0, "R9");
        expect_at(LOSS, 2, 1'b0, "R8");
        expect_at(LOSS + 1, 2, 1'b1, "R8");
        nlp_stb = 1'b1;
        tick();
        nlp_stb = 1'b0;
        repeat (LOSS + 3) tick();

        // R7: a single valid packet
        expect_at(0, 2, 1'b1, "R7");
        expect_at(1, 2, 1'b0, "R7");
        expect_at(LOSS + 1, 2, 1'b1, "R8");
        pkt_ok_stb = 1'b1;
        tick();
        pkt_ok_stb = 1'b0;
        repeat (LOSS + 3) tick();

        finish_run();
    end
endmodule